// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block is the bus-cycle engine of a single DMA channel. It holds two address counters (A and B) and a length counter, and moves data items one at a time between a requesting peripheral and the system bus. In flyby mode each item costs one bus cycle: the addressed device is read and the data is handed to the peripheral, or peripheral data is written to the addressed device. In two-cycle mode a read lands in a holding register and the following cycle writes it back out. This supports memory-to-memory moves.

Counters are loaded while the channel is disabled. After it is enabled, the peripheral raises its request and the block runs until the length counter is exhausted. Each move is acknowledged to the peripheral. A one-cycle completion pulse marks the moment the count reaches zero. A policy bit chooses back-to-back bus cycles, or spaced cycles that leave the bus free for other masters in between.

Top module: `dma_chan_seq`

## Requirements
- R1: While reset is high, and on the first cycle after it, there is no bus read or write, `io_ack` and `done` are low, and `cnt_left` reads 0.
- R2: A pulse on `ld_valid` while `cfg_en` is low loads both address counters and the length counter; `cnt_left` shows the new count on the next cycle. While `cfg_en` is high, `ld_valid` has no effect.
- R3: A transfer begins only when `cfg_en` and `io_req` are both high and `cnt_left` is nonzero. With the request low or the count at zero, no bus cycle is issued.
- R4: Flyby mode (`cfg_indirect`=0), `cfg_dir`=0: the bus is read at counter A. `io_rdata` carries the read data, and `io_ack` is high, in that same cycle.
- R5: Flyby mode, `cfg_dir`=1: the bus is written at counter A with `io_wdata`, and `io_ack` is high, in that same cycle.
- R6: Two-cycle mode, `cfg_dir`=0: a read at counter A is followed in the very next cycle by a write at counter B of the data read. `io_ack` is high with the write.
- R7: Two-cycle mode, `cfg_dir`=1: the read uses counter B and the following write uses counter A.
- R8: With the request held, successive transfers start every 1 clock in flyby mode with `cfg_cont`=1, and every 3 clocks with `cfg_cont`=0. In two-cycle mode they start every 2 clocks with `cfg_cont`=1, and every 5 clocks with `cfg_cont`=0.
- R9: `cfg_wide`=1 moves 16 bits with `bus_be`=2'b11 and an address step of 2. `cfg_wide`=0 moves 8 bits with `bus_be`=2'b01 and an address step of 1. In that case bits 15:8 of `bus_wdata` and `io_rdata` are zero.
- R10: Each address counter follows its own 2-bit mode: 2'b00 and 2'b11 hold, 2'b01 increments, and 2'b10 decrements. A counter steps after each bus cycle that uses it.
- R11: The length counter drops by exactly one per moved item, in the cycle after `io_ack`.
- R12: `done` is high for exactly one cycle: the cycle after the bus cycle of the last item, which is also the first cycle in which `cnt_left` reads 0.
- R13: `bus_rd` and `bus_wr` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_en | input | 1 | Channel enable |
| cfg_indirect | input | 1 | 1 selects two-cycle (read then write) mode |
| cfg_dir | input | 1 | Direction; swaps source and destination |
| cfg_wide | input | 1 | 1 selects 16-bit items, 0 selects 8-bit items |
| cfg_cont | input | 1 | 1 selects back-to-back bus cycles |
| cfg_amode_a | input | 2 | Step mode of address counter A |
| cfg_amode_b | input | 2 | Step mode of address counter B |
| ld_valid | input | 1 | Load strobe for the counters |
| ld_addr_a | input | AW | Start value for counter A |
| ld_addr_b | input | AW | Start value for counter B |
| ld_count | input | CW | Number of items to move |
| io_req | input | 1 | Peripheral transfer request |
| io_ack | output | 1 | Peripheral acknowledge, one cycle per item |
| io_wdata | input | 16 | Data supplied by the peripheral |
| io_rdata | output | 16 | Data delivered to the peripheral |
| bus_addr | output | AW | Bus address |
| bus_rd | output | 1 | Bus read strobe |
| bus_wr | output | 1 | Bus write strobe |
| bus_be | output | 2 | Byte lane enables |
| bus_wdata | output | 16 | Bus write data |
| bus_rdata | input | 16 | Bus read data, valid in the strobe cycle |
| cnt_left | output | CW | Items remaining |
| done | output | 1 | Completion pulse |

## Verification
The final decrement of the length counter and a still-asserted request meet in the same cycle: the peripheral keeps asking while the last item moves. The bench keeps `io_req` high for several cycles after the count reaches zero in every scenario, across both modes and both policies. Any extra bus cycle in that window is reported, because the scoreboard queue is already empty. The cycle in which `done` appears is compared with the cycle of the last recorded bus strobe.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    localparam int DATA_W       = 16;
    localparam int LANES        = DATA_W / 8;
    localparam int GAP_FLYBY    = 2;
    localparam int GAP_TWOCYC   = 3;
    localparam int GAP_W        = $clog2(GAP_TWOCYC + 1);

    typedef enum logic [1:0] {
        AM_HOLD  = 2'b00,
        AM_INC   = 2'b01,
        AM_DEC   = 2'b10,
        AM_HOLD2 = 2'b11
    } amode_e;

    typedef enum logic [1:0] {
        ST_READY = 2'b00,
        ST_WRITE = 2'b01,
        ST_GAP   = 2'b10
    } state_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic use_b;
        logic ack;
        logic dec;
        logic step_a;
        logic step_b;
        logic latch;
    } ctl_s;

    function automatic logic signed [2:0] addr_delta(amode_e m, logic wide);
        logic signed [2:0] mag;
        mag = wide ? 3'sd2 : 3'sd1;
        case (m)
            AM_INC:  return mag;
            AM_DEC:  return -mag;
            default: return 3'sd0;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] lane_mask(logic wide);
        return wide ? {DATA_W{1'b1}} : {{(DATA_W-8){1'b0}}, 8'hFF};
    endfunction

endpackage

// File: rtl/dma_addr_ctr.sv
module dma_addr_ctr
    import dma_seq_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step,
    input  amode_e        mode,
    input  logic          wide,
    output logic [AW-1:0] addr
);
    logic signed [2:0] delta;
    logic [AW-1:0]     delta_ext;

    assign delta     = addr_delta(mode, wide);
    assign delta_ext = {{(AW-3){delta[2]}}, delta};

    always_ff @(posedge clk) begin
        if (rst)       addr <= '0;
        else if (load) addr <= load_val;
        else if (step) addr <= addr + delta_ext;
    end
endmodule

// File: rtl/dma_len_ctr.sv
module dma_len_ctr #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic [CW-1:0] count,
    output logic          nonzero,
    output logic          last_pulse
);
    localparam logic [CW-1:0] ONE = CW'(1);

    assign nonzero = (count != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            count      <= '0;
            last_pulse <= 1'b0;
        end else begin
            last_pulse <= dec && (count == ONE);
            if (load)     count <= load_val;
            else if (dec) count <= count - ONE;
        end
    end
endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
    import dma_seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic req,
    input  logic indirect,
    input  logic dir,
    input  logic cont,
    input  logic nonzero,
    output ctl_s ctl
);
    state_e            state_q, state_d;
    logic [GAP_W-1:0]  gap_q, gap_d;
    logic              go;

    assign go = (state_q == ST_READY) && en && req && nonzero;

    always_comb begin
        ctl     = '0;
        state_d = state_q;
        gap_d   = gap_q;
        case (state_q)
            ST_READY: begin
                if (go) begin
                    if (!indirect) begin
                        ctl.rd     = !dir;
                        ctl.wr     = dir;
                        ctl.ack    = 1'b1;
                        ctl.dec    = 1'b1;
                        ctl.step_a = 1'b1;
                        if (!cont) begin
                            state_d = ST_GAP;
                            gap_d   = GAP_W'(GAP_FLYBY - 1);
                        end
                    end else begin
                        ctl.rd     = 1'b1;
                        ctl.use_b  = dir;
                        ctl.latch  = 1'b1;
                        ctl.step_a = !dir;
                        ctl.step_b = dir;
                        state_d    = ST_WRITE;
                    end
                end
            end
            ST_WRITE: begin
                ctl.wr     = 1'b1;
                ctl.use_b  = !dir;
                ctl.ack    = 1'b1;
                ctl.dec    = 1'b1;
                ctl.step_a = dir;
                ctl.step_b = !dir;
                if (cont) begin
                    state_d = ST_READY;
                end else begin
                    state_d = ST_GAP;
                    gap_d   = GAP_W'(GAP_TWOCYC - 1);
                end
            end
            ST_GAP: begin
                if (gap_q == '0) state_d = ST_READY;
                else             gap_d   = gap_q - GAP_W'(1);
            end
            default: state_d = ST_READY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_READY;
            gap_q   <= '0;
        end else begin
            state_q <= state_d;
            gap_q   <= gap_d;
        end
    end
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
    import dma_seq_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_en,
    input  logic              cfg_indirect,
    input  logic              cfg_dir,
    input  logic              cfg_wide,
    input  logic              cfg_cont,
    input  logic [1:0]        cfg_amode_a,
    input  logic [1:0]        cfg_amode_b,
    input  logic              ld_valid,
    input  logic [AW-1:0]     ld_addr_a,
    input  logic [AW-1:0]     ld_addr_b,
    input  logic [CW-1:0]     ld_count,
    input  logic              io_req,
    output logic              io_ack,
    input  logic [DATA_W-1:0] io_wdata,
    output logic [DATA_W-1:0] io_rdata,
    output logic [AW-1:0]     bus_addr,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic [LANES-1:0]  bus_be,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic [CW-1:0]     cnt_left,
    output logic              done
);
    ctl_s               ctl;
    logic               load_ok;
    logic               nonzero;
    logic [AW-1:0]      addr_a, addr_b;
    logic [DATA_W-1:0]  mask;
    logic [DATA_W-1:0]  hold_q;

    assign load_ok = ld_valid && !cfg_en;
    assign mask    = lane_mask(cfg_wide);

    dma_seq_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .en       (cfg_en),
        .req      (io_req),
        .indirect (cfg_indirect),
        .dir      (cfg_dir),
        .cont     (cfg_cont),
        .nonzero  (nonzero),
        .ctl      (ctl)
    );

    dma_addr_ctr #(.AW(AW)) u_ctr_a (
        .clk      (clk),
        .rst      (rst),
        .load     (load_ok),
        .load_val (ld_addr_a),
        .step     (ctl.step_a),
        .mode     (amode_e'(cfg_amode_a)),
        .wide     (cfg_wide),
        .addr     (addr_a)
    );

    dma_addr_ctr #(.AW(AW)) u_ctr_b (
        .clk      (clk),
        .rst      (rst),
        .load     (load_ok),
        .load_val (ld_addr_b),
        .step     (ctl.step_b),
        .mode     (amode_e'(cfg_amode_b)),
        .wide     (cfg_wide),
        .addr     (addr_b)
    );

    dma_len_ctr #(.CW(CW)) u_len (
        .clk        (clk),
        .rst        (rst),
        .load       (load_ok),
        .load_val   (ld_count),
        .dec        (ctl.dec),
        .count      (cnt_left),
        .nonzero    (nonzero),
        .last_pulse (done)
    );

    always_ff @(posedge clk) begin
        if (rst)            hold_q <= '0;
        else if (ctl.latch) hold_q <= bus_rdata & mask;
    end

    assign bus_rd    = ctl.rd;
    assign bus_wr    = ctl.wr;
    assign io_ack    = ctl.ack;
    assign bus_addr  = ctl.use_b ? addr_b : addr_a;
    assign bus_be    = (ctl.rd || ctl.wr) ? (cfg_wide ? 2'b11 : 2'b01) : 2'b00;
    assign bus_wdata = ctl.wr ? (cfg_indirect ? hold_q : (io_wdata & mask)) : '0;
    assign io_rdata  = (ctl.ack && ctl.rd) ? (bus_rdata & mask) : '0;
endmodule

// File: rtl/dma_chan_seq_chk.sv
module dma_chan_seq_chk #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          cfg_en,
    input logic          cfg_indirect,
    input logic          cfg_cont,
    input logic          cfg_wide,
    input logic          io_ack,
    input logic          bus_rd,
    input logic          bus_wr,
    input logic [15:0]   bus_wdata,
    input logic [CW-1:0] cnt_left,
    input logic          done
);
    // R13
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd && bus_wr));

    // R11
    len_step_chk: assert property (@(posedge clk) disable iff (rst)
        io_ack |=> (cnt_left == CW'($past(cnt_left) - CW'(1))));

    // R12
    done_zero_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (cnt_left == '0) && ($past(cnt_left) == CW'(1)));

    // R3
    no_run_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_left == '0) |-> !(bus_rd || bus_wr));

    // R6
    twocyc_pair_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && cfg_indirect) |=> (bus_wr && !bus_rd));

    // R8
    flyby_gap_chk: assert property (@(posedge clk) disable iff (rst)
        ((bus_rd || bus_wr) && !cfg_indirect && !cfg_cont)
        |=> !(bus_rd || bus_wr) ##1 !(bus_rd || bus_wr));

    // R2
    hold_enabled_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_en && !io_ack) |=> $stable(cnt_left));

    // R9
    byte_lane_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !cfg_wide) |-> (bus_wdata[15:8] == 8'h00));
endmodule

bind dma_chan_seq dma_chan_seq_chk #(.CW(CW)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .cfg_en       (cfg_en),
    .cfg_indirect (cfg_indirect),
    .cfg_cont     (cfg_cont),
    .cfg_wide     (cfg_wide),
    .io_ack       (io_ack),
    .bus_rd       (bus_rd),
    .bus_wr       (bus_wr),
    .bus_wdata    (bus_wdata),
    .cnt_left     (cnt_left),
    .done         (done)
);

// File: tb/dma_chan_seq_tb_top.sv
module dma_chan_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          cfg_en, cfg_indirect, cfg_dir, cfg_wide, cfg_cont;
    logic [1:0]    cfg_amode_a, cfg_amode_b;
    logic          ld_valid;
    logic [AW-1:0] ld_addr_a, ld_addr_b;
    logic [CW-1:0] ld_count;
    logic          io_req, io_ack;
    logic [15:0]   io_wdata, io_rdata;
    logic [AW-1:0] bus_addr;
    logic          bus_rd, bus_wr;
    logic [1:0]    bus_be;
    logic [15:0]   bus_wdata, bus_rdata;
    logic [CW-1:0] cnt_left;
    logic          done;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] mem_val(logic [15:0] a);
        return {a[7:0] ^ 8'hA5, a[15:8] ^ a[7:0] ^ 8'h3C};
    endfunction

    function automatic logic [15:0] io_val(logic [15:0] c);
        return {8'hD0 ^ c[7:0], 8'h17 + c[7:0]};
    endfunction

    function automatic logic [15:0] adv(logic [15:0] a, logic [1:0] m, logic w);
        logic [15:0] s;
        s = w ? 16'd2 : 16'd1;
        case (m)
            2'b01:   return a + s;
            2'b10:   return a - s;
            default: return a;
        endcase
    endfunction

    assign bus_rdata = mem_val(bus_addr);
    assign io_wdata  = io_val(cnt_left);

    dma_chan_seq #(.AW(AW), .CW(CW)) dut_i (
        .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_indirect(cfg_indirect),
        .cfg_dir(cfg_dir), .cfg_wide(cfg_wide), .cfg_cont(cfg_cont),
        .cfg_amode_a(cfg_amode_a), .cfg_amode_b(cfg_amode_b),
        .ld_valid(ld_valid), .ld_addr_a(ld_addr_a), .ld_addr_b(ld_addr_b),
        .ld_count(ld_count), .io_req(io_req), .io_ack(io_ack),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .bus_addr(bus_addr),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_be(bus_be),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cnt_left(cnt_left), .done(done)
    );

    typedef struct {
        logic        rd;
        logic        wr;
        logic [15:0] addr;
        logic [1:0]  be;
        logic        ack;
        logic [15:0] data;
        int          delta;
        string       tag;
    } item_t;

    item_t exp_q[$];
    int    n_checks = 0;
    int    n_fails  = 0;
    int    cyc      = 0;
    int    prev_cyc = -1;
    int    last_bus_cyc = -1;
    int    done_cyc = -1;
    int    done_cnt = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit ok, string tag, string what, logic [63:0] act, logic [63:0] expv);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
        end
    endtask

    task automatic wrap_up();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    // Monitor: pops expected bus events and compares them
    always @(negedge clk) begin
        if (!rst) begin
            if (done) begin
                done_cnt++;
                done_cyc = cyc;
            end
            if (bus_rd || bus_wr) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3", "unexpected bus cycle",
                          {bus_rd, bus_wr, bus_addr}, 64'h0);
                end else begin
                    item_t e;
                    logic [15:0] dact;
                    e = exp_q.pop_front();
                    dact = bus_wr ? bus_wdata : (io_ack ? io_rdata : 16'h0);
                    check({bus_rd, bus_wr, bus_addr, bus_be, io_ack, dact} ==
                          {e.rd, e.wr, e.addr, e.be, e.ack, e.data}, e.tag,
                          "bus event {rd,wr,addr,be,ack,data}",
                          {bus_rd, bus_wr, bus_addr, bus_be, io_ack, dact},
                          {e.rd, e.wr, e.addr, e.be, e.ack, e.data});
                    if (e.delta > 0 && prev_cyc >= 0)
                        check((cyc - prev_cyc) == e.delta, "R8", "cycle spacing",
                              64'(cyc - prev_cyc), 64'(e.delta));
                end
                prev_cyc = cyc;
                last_bus_cyc = cyc;
            end
        end
    end

    // Driver: loads a scenario, queues expected events, runs it, checks the end
    task automatic run_case(bit ind, bit dir, bit wide, bit cont,
                            logic [1:0] ma, logic [1:0] mb,
                            logic [15:0] a0, logic [15:0] b0, int n);
        logic [15:0] a, b, c, m, src, dst;
        @(negedge clk);
        cfg_en = 0; io_req = 0;
        cfg_indirect = ind; cfg_dir = dir; cfg_wide = wide; cfg_cont = cont;
        cfg_amode_a = ma; cfg_amode_b = mb;
        ld_valid = 1; ld_addr_a = a0; ld_addr_b = b0; ld_count = CW'(n);
        @(negedge clk);
        ld_valid = 0;
        // R2: load while disabled
        check(cnt_left == CW'(n), "R2", "count after load", 64'(cnt_left), 64'(n));
        a = a0; b = b0; c = 16'(n);
        m = wide ? 16'hFFFF : 16'h00FF;
        for (int i = 0; i < n; i++) begin
            if (!ind) begin
                // R4 / R5 flyby, R9 lanes, R10 address mode A
                exp_q.push_back('{rd: !dir, wr: dir, addr: a,
                    be: wide ? 2'b11 : 2'b01, ack: 1'b1,
                    data: dir ? (io_val(c) & m) : (mem_val(a) & m),
                    delta: (i == 0) ? 0 : (cont ? 1 : 3),
                    tag: dir ? "R5" : "R4"});
                a = adv(a, ma, wide);
            end else begin
                // R6 / R7 two-cycle, R10 both counters
                src = dir ? b : a;
                dst = dir ? a : b;
                exp_q.push_back('{rd: 1'b1, wr: 1'b0, addr: src,
                    be: wide ? 2'b11 : 2'b01, ack: 1'b0, data: 16'h0,
                    delta: (i == 0) ? 0 : (cont ? 1 : 4),
                    tag: dir ? "R7" : "R6"});
                exp_q.push_back('{rd: 1'b0, wr: 1'b1, addr: dst,
                    be: wide ? 2'b11 : 2'b01, ack: 1'b1,
                    data: mem_val(src) & m, delta: 1,
                    tag: dir ? "R7" : "R6"});
                a = adv(a, ma, wide);
                b = adv(b, mb, wide);
            end
            c = c - 16'd1;
        end
        prev_cyc = -1;
        done_cnt = 0;
        done_cyc = -1;
        cfg_en = 1; io_req = 1;
        for (int k = 0; k < n * 6 + 10; k++) begin
            @(negedge clk);
            if (cnt_left == '0) break;
        end
        // R3: request stays high with count at zero; no further cycles expected
        repeat (5) @(negedge clk);
        io_req = 0; cfg_en = 0;
        check(exp_q.size() == 0, "R11", "items left unmoved", 64'(exp_q.size()), 64'h0);
        exp_q.delete();
        check(cnt_left == '0, "R11", "final count", 64'(cnt_left), 64'h0);
        // R12: one pulse, right after the last bus cycle
        check(done_cnt == 1, "R12", "done pulse count", 64'(done_cnt), 64'h1);
        check(done_cyc == last_bus_cyc + 1, "R12", "done cycle",
              64'(done_cyc), 64'(last_bus_cyc + 1));
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        wrap_up();
    end

    initial begin
        rst = 1; cfg_en = 0; cfg_indirect = 0; cfg_dir = 0; cfg_wide = 0;
        cfg_cont = 0; cfg_amode_a = 2'b00; cfg_amode_b = 2'b00;
        ld_valid = 0; ld_addr_a = '0; ld_addr_b = '0; ld_count = '0; io_req = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check({bus_rd, bus_wr, io_ack, done} == 4'b0 && cnt_left == '0, "R1",
              "reset outputs", {bus_rd, bus_wr, io_ack, done, cnt_left}, 64'h0);
        rst = 0;
        @(negedge clk);
        check({bus_rd, bus_wr, io_ack, done} == 4'b0 && cnt_left == '0, "R1",
              "after reset", {bus_rd, bus_wr, io_ack, done, cnt_left}, 64'h0);

        // R3 and R2: enabled without request, then a load attempt while enabled
        ld_valid = 1; ld_addr_a = 16'h0040; ld_count = 16'd2;
        @(negedge clk);
        ld_valid = 0; cfg_en = 1;
        repeat (4) @(negedge clk);
        check(cnt_left == 16'd2, "R3", "no transfer without request",
              64'(cnt_left), 64'd2);
        ld_valid = 1; ld_count = 16'd7;
        @(negedge clk);
        ld_valid = 0;
        @(negedge clk);
        check(cnt_left == 16'd2, "R2", "load ignored while enabled",
              64'(cnt_left), 64'd2);
        cfg_en = 0;

        // R4 R9 R10: flyby read, bytes, A increments, back-to-back
        run_case(0, 0, 0, 1, 2'b01, 2'b00, 16'h0100, 16'h0000, 4);
        // R5 R8 R10: flyby write, 16-bit, A decrements, spaced
        run_case(0, 1, 1, 0, 2'b10, 2'b00, 16'h0200, 16'h0000, 3);
        // R6 R9 R10: two-cycle A->B, 16-bit, A inc, B dec, back-to-back
        run_case(1, 0, 1, 1, 2'b01, 2'b10, 16'h1000, 16'h2000, 3);
        // R7 R8 R10: two-cycle B->A, bytes, A held (11), B inc, spaced
        run_case(1, 1, 0, 0, 2'b11, 2'b01, 16'h3000, 16'h40FE, 3);
        // R10: flyby with A held (00), 16-bit, single item boundary
        run_case(0, 0, 1, 1, 2'b00, 2'b01, 16'h0AAA, 16'h0000, 1);
        // R4 R8: flyby read, bytes, spaced, A increments across a byte boundary
        run_case(0, 0, 0, 0, 2'b01, 2'b00, 16'h00FE, 16'h0000, 3);

        repeat (3) @(negedge clk);
        wrap_up();
    end
endmodule